// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register file of a small 32-bit RISC core that runs in one of six operating modes. Software in every mode addresses sixteen logical registers through a 4-bit number. Some of those numbers are backed by per-mode physical copies. When an exception switches the mode, the handler gets its own stack pointer and link register at once, and the fast-interrupt handler also gets its own upper working registers, with no save to memory.

The block holds the current mode. The mode changes either through a software mode write or through an exception-entry strobe. On that strobe, at one clock edge, it switches to the target mode, writes the supplied return address into the target mode's link register and copies the current status word into that mode's saved-status register. Logical register 15 is the program counter, which lives outside the block. Reads of it return the `pc_in` input, and writes to it are sent out on a separate PC-write output. The array has two combinational read ports and one write port.

The six modes and their 5-bit encodings are: user `10000`, fast interrupt `10001`, normal interrupt `10010`, supervisor `10011`, abort `10111` and undefined instruction `11011`. The array stores thirty 32-bit physical registers, and the external program counter brings the total to thirty-one.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low and after its release, `cur_mode` is user (`10000`), every logical register 0 to 14 reads 0 in every mode, and `spsr_data` reads 0.
- R2: In user mode, logical registers 0 to 14 select the unbanked set. Reads are combinational in the current mode.
- R3: In fast-interrupt mode (`10001`), registers 8 to 14 are private copies. Registers 0 to 7 are shared with user mode.
- R4: Normal-interrupt (`10010`), supervisor (`10011`), abort (`10111`) and undefined (`11011`) modes each have private copies of registers 13 and 14 only. Registers 0 to 12 are shared with user mode.
- R5: Reading logical register 15 on either read port returns `pc_in` in the same cycle.
- R6: A write to logical register 15 raises `pc_we` in the same cycle with `pc_wdata` equal to `wr_data`, and it changes no stored register. `pc_we` is low at all other times.
- R7: A write takes effect at the clock edge. A read of the same register in the same cycle returns the old value.
- R8: When `exc_take` is high at a clock edge, `cur_mode` becomes `exc_mode`. At that same edge the target mode's register 14 becomes `exc_ret`, and the target mode's saved status becomes `cpsr_in`. All three are visible in the next cycle.
- R9: `exc_take` has priority over `mode_we`. A regular write in the same cycle is mapped with the mode that held before the edge. If that write hits the same physical register as the link capture, the capture wins.
- R10: `spsr_data` shows the saved status of the current mode. In user mode it shows 0.
- R11: A mode encoding outside the six listed acts as user mode for register selection and for `spsr_data`, while `cur_mode` shows the raw value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Software mode write strobe |
| mode_wdata | input | 5 | New mode for a software mode write |
| exc_take | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret | input | 32 | Return address captured into the target link register |
| cpsr_in | input | 32 | Current status word, saved on exception entry |
| pc_in | input | 32 | Program counter value returned for register 15 |
| ra_idx | input | 4 | Read port A logical register number |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B logical register number |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical register number |
| wr_data | input | 32 | Write data |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | Program counter write data |
| cur_mode | output | 5 | Current mode |
| spsr_data | output | 32 | Saved status of the current mode |

## Verification
The bench builds the block with its default 32-bit data width. At that width all thirty physical entries and all five saved-status registers can be reached through the six modes, and distinct data patterns can mark which bank a value came from. A behavioural model keeps one copy per mode and resolves ownership from the requirement rules. The bench compares both read ports, the mode, the saved status and the PC-write outputs against that model on every clock. The stimulus covers exception entry that collides with a software mode write and with a regular write to the same link register.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int NUM_LOG   = 16;
  localparam int LIDX_W    = $clog2(NUM_LOG);
  localparam int PC_IDX    = NUM_LOG - 1;
  localparam int LINK_IDX  = PC_IDX - 1;
  localparam int SP_IDX    = PC_IDX - 2;
  localparam int FIQ_FIRST = 8;
  localparam int FIQ_CNT   = PC_IDX - FIQ_FIRST;
  localparam int PAIR_CNT  = PC_IDX - SP_IDX;
  localparam int NUM_BANKS = 6;
  localparam int PAIR_BANKS = NUM_BANKS - 2;
  localparam int FIQ_BASE  = PC_IDX;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;
  localparam int NPHYS     = PAIR_BASE + PAIR_CNT * PAIR_BANKS;
  localparam int PIDX_W    = $clog2(NPHYS);
  localparam int MODE_W    = 5;

  typedef logic [2:0] bank_t;
  localparam bank_t BANK_USR = 3'd0;
  localparam bank_t BANK_FIQ = 3'd1;
  localparam bank_t BANK_IRQ = 3'd2;
  localparam bank_t BANK_SVC = 3'd3;
  localparam bank_t BANK_ABT = 3'd4;
  localparam bank_t BANK_UND = 3'd5;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011
  } mode_e;

  function automatic bank_t bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: bank_of = BANK_FIQ;
      MODE_IRQ: bank_of = BANK_IRQ;
      MODE_SVC: bank_of = BANK_SVC;
      MODE_ABT: bank_of = BANK_ABT;
      MODE_UND: bank_of = BANK_UND;
      default:  bank_of = BANK_USR;
    endcase
  endfunction
endpackage

// File: rtl/bankreg_mode_ctrl.sv
module bankreg_mode_ctrl
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              exc_take,
  input  logic [MODE_W-1:0] exc_mode,
  output logic [MODE_W-1:0] mode_q,
  output bank_t             bank_cur,
  output bank_t             bank_exc
);
  logic [MODE_W-1:0] mode_d;
  logic              mode_en;

  always_comb begin
    mode_en = exc_take | mode_we;
    mode_d  = mode_q;
    if (exc_take)     mode_d = exc_mode;
    else if (mode_we) mode_d = mode_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_USR;
    else if (mode_en) mode_q <= mode_d;
  end

  assign bank_cur = bank_of(mode_q);
  assign bank_exc = bank_of(exc_mode);

  // R8 / R9: exception entry sets the mode even when a software write competes
  a_r9_exc_priority: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> mode_q == $past(exc_mode));
  a_r9_sw_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !exc_take) |=> mode_q == $past(mode_wdata));
  a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_we && !exc_take) |=> $stable(mode_q));
endmodule

// File: rtl/bankreg_phys_map.sv
module bankreg_phys_map
  import bankreg_pkg::*;
(
  input  bank_t             bank,
  input  logic [LIDX_W-1:0] log_idx,
  output logic [PIDX_W-1:0] phys_idx
);
  int li;
  int pi;

  always_comb begin
    li = int'(log_idx);
    pi = li;
    if (bank == BANK_FIQ && li >= FIQ_FIRST && li < PC_IDX)
      pi = FIQ_BASE + (li - FIQ_FIRST);
    else if (bank >= BANK_IRQ && bank <= BANK_UND && li >= SP_IDX && li < PC_IDX)
      pi = PAIR_BASE + (int'(bank) - int'(BANK_IRQ)) * PAIR_CNT + (li - SP_IDX);
    phys_idx = PIDX_W'(pi);
  end

  // R3 / R4: banked mapping stays inside the physical array
  always_comb begin
    a_r4_in_range: assert (int'(phys_idx) < NPHYS);
  end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [PIDX_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [PIDX_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [PIDX_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_q,
  input  logic [PIDX_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_q
);
  logic [DATA_W-1:0] mem_q [NPHYS];

  for (genvar g = 0; g < NPHYS; g++) begin : g_entry
    logic              hit_a;
    logic              hit_b;
    logic              ent_en;
    logic [DATA_W-1:0] ent_d;

    always_comb begin
      hit_a  = wa_en && (int'(wa_addr) == g);
      hit_b  = wb_en && (int'(wb_addr) == g);
      ent_en = hit_a | hit_b;
      ent_d  = hit_b ? wb_data : wa_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= '0;
      else if (ent_en) mem_q[g] <= ent_d;
    end
  end

  assign ra_q = mem_q[ra_addr];
  assign rb_q = mem_q[rb_addr];

  // R8: link capture lands in the addressed entry
  a_r8_link_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> mem_q[$past(wb_addr)] == $past(wb_data));
  // R7 / R9: regular write lands unless the capture hits the same entry
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && !(wb_en && wb_addr == wa_addr)) |=> mem_q[$past(wa_addr)] == $past(wa_data));
endmodule

// File: rtl/bankreg_spsr.sv
module bankreg_spsr
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  bank_t             cap_bank,
  input  logic [DATA_W-1:0] cap_data,
  input  bank_t             rd_bank,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NSAVED = NUM_BANKS - 1;
  logic [DATA_W-1:0] sv_q [NSAVED];

  for (genvar g = 0; g < NSAVED; g++) begin : g_saved
    logic sv_en;
    always_comb sv_en = cap_en && (int'(cap_bank) == g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sv_q[g] <= '0;
      else if (sv_en) sv_q[g] <= cap_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSAVED; i++)
      if (int'(rd_bank) == i + 1) rd_data = sv_q[i];
  end

  // R8: status word saved for an exception-mode target
  a_r8_status_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_bank != BANK_USR) |=> sv_q[int'($past(cap_bank)) - 1] == $past(cap_data));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [4:0]        mode_wdata,
  input  logic              exc_take,
  input  logic [4:0]        exc_mode,
  input  logic [DATA_W-1:0] exc_ret,
  input  logic [DATA_W-1:0] cpsr_in,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [3:0]        ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_wdata,
  output logic [4:0]        cur_mode,
  output logic [DATA_W-1:0] spsr_data
);
  localparam logic [LIDX_W-1:0] PC_L   = LIDX_W'(PC_IDX);
  localparam logic [LIDX_W-1:0] LINK_L = LIDX_W'(LINK_IDX);

  bank_t             bank_cur, bank_exc;
  logic [PIDX_W-1:0] pa_a, pa_b, pa_w, pa_x;
  logic [DATA_W-1:0] arr_a, arr_b;
  logic              arr_we;

  bankreg_mode_ctrl u_mode (
    .clk, .rst_n, .mode_we, .mode_wdata, .exc_take, .exc_mode,
    .mode_q(cur_mode), .bank_cur, .bank_exc
  );

  bankreg_phys_map u_map_a (.bank(bank_cur), .log_idx(ra_idx), .phys_idx(pa_a));
  bankreg_phys_map u_map_b (.bank(bank_cur), .log_idx(rb_idx), .phys_idx(pa_b));
  bankreg_phys_map u_map_w (.bank(bank_cur), .log_idx(wr_idx), .phys_idx(pa_w));
  bankreg_phys_map u_map_x (.bank(bank_exc), .log_idx(LINK_L), .phys_idx(pa_x));

  assign arr_we   = wr_en && (wr_idx != PC_L);
  assign pc_we    = wr_en && (wr_idx == PC_L);
  assign pc_wdata = wr_data;

  bankreg_store #(.DATA_W(DATA_W)) u_store (
    .clk, .rst_n,
    .wa_en(arr_we),   .wa_addr(pa_w), .wa_data(wr_data),
    .wb_en(exc_take), .wb_addr(pa_x), .wb_data(exc_ret),
    .ra_addr(pa_a), .ra_q(arr_a),
    .rb_addr(pa_b), .rb_q(arr_b)
  );

  bankreg_spsr #(.DATA_W(DATA_W)) u_spsr (
    .clk, .rst_n,
    .cap_en(exc_take), .cap_bank(bank_exc), .cap_data(cpsr_in),
    .rd_bank(bank_cur), .rd_data(spsr_data)
  );

  assign ra_data = (ra_idx == PC_L) ? pc_in : arr_a;
  assign rb_data = (rb_idx == PC_L) ? pc_in : arr_b;

  // R10: user-class modes never expose a saved status
  a_r10_user_no_spsr: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_cur == BANK_USR) |-> spsr_data == '0);
  // R6: a PC write leaves the array write port idle
  a_r6_pc_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> !arr_we);
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we, exc_take, wr_en;
  logic [4:0]  mode_wdata, exc_mode;
  logic [31:0] exc_ret, cpsr_in, pc_in, wr_data;
  logic [3:0]  ra_idx, rb_idx, wr_idx;
  logic [31:0] ra_data, rb_data, pc_wdata, spsr_data;
  logic        pc_we;
  logic [4:0]  cur_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] mdl [0:5][0:14];
  logic [31:0] msv [0:5];
  logic [4:0]  mmode;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u_dut (
    .clk, .rst_n, .mode_we, .mode_wdata, .exc_take, .exc_mode, .exc_ret,
    .cpsr_in, .pc_in, .ra_idx, .ra_data, .rb_idx, .rb_data, .wr_en, .wr_idx,
    .wr_data, .pc_we, .pc_wdata, .cur_mode, .spsr_data
  );

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic int owner(input int b, input int r);
    if (b == 1 && r >= 8) return 1;
    if (b >= 2 && r >= 13) return b;
    return 0;
  endfunction

  function automatic logic [31:0] mread(input int r);
    if (r == 15) return pc_in;
    return mdl[owner(bk(mmode), r)][r];
  endfunction

  function automatic string rtag(input int r);
    if (wr_en && int'(wr_idx) == r && r != 15) return "R7";
    if (r == 15) return "R5";
    if (bk(mmode) == 1) return "R3";
    if (bk(mmode) >= 2) return "R4";
    if (mmode != 5'b10000) return "R11";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    int b;
    #1;
    chk(rtag(int'(ra_idx)), ra_data, mread(int'(ra_idx)));
    chk(rtag(int'(rb_idx)), rb_data, mread(int'(rb_idx)));
    chk((bk(mmode) == 0) ? "R10" : "R8", spsr_data, msv[bk(mmode)]);
    chk("R6", {31'd0, pc_we}, {31'd0, wr_en && wr_idx == 4'd15});
    if (wr_en && wr_idx == 4'd15) chk("R6", pc_wdata, wr_data);
    @(posedge clk);
    if (wr_en && wr_idx != 4'd15)
      mdl[owner(bk(mmode), int'(wr_idx))][int'(wr_idx)] = wr_data;
    if (exc_take) begin
      b = bk(exc_mode);
      mdl[owner(b, 14)][14] = exc_ret;
      if (b != 0) msv[b] = cpsr_in;
      mmode = exc_mode;
    end else if (mode_we) begin
      mmode = mode_wdata;
    end
    @(negedge clk);
    chk((exc_take && mode_we) ? "R9" : "R8", {27'd0, cur_mode}, {27'd0, mmode});
    wr_en = 0; mode_we = 0; exc_take = 0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    mode_we = 1; mode_wdata = m; tick();
  endtask

  task automatic read_all(input int base);
    for (int r = 0; r < 16; r++) begin
      ra_idx = 4'(r); rb_idx = 4'((r + base) % 16); tick();
    end
  endtask

  task automatic write_reg(input int r, input logic [31:0] v);
    wr_en = 1; wr_idx = 4'(r); wr_data = v; ra_idx = 4'(r); rb_idx = 4'(r); tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 6; b++) begin
      msv[b] = '0;
      for (int r = 0; r < 15; r++) mdl[b][r] = '0;
    end
    mmode = 5'b10000;
    rst_n = 0; mode_we = 0; exc_take = 0; wr_en = 0;
    mode_wdata = '0; exc_mode = '0; exc_ret = '0; cpsr_in = '0; pc_in = 32'h0000_0100;
    ra_idx = '0; rb_idx = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", {27'd0, cur_mode}, {27'd0, 5'b10000});
    chk("R1", spsr_data, 32'd0);
    for (int r = 0; r < 15; r++) begin
      ra_idx = 4'(r); #1; chk("R1", ra_data, 32'd0);
    end
    rst_n = 1;
    @(negedge clk);
    chk("R1", {27'd0, cur_mode}, {27'd0, 5'b10000});
    // R2 / R7: user writes, same-cycle read returns old value
    for (int r = 0; r < 15; r++) write_reg(r, 32'h1000_0000 + r);
    read_all(3);
    // R3: fast-interrupt private copies
    set_mode(5'b10001);
    read_all(5);
    for (int r = 8; r < 15; r++) write_reg(r, 32'h2000_0000 + r);
    read_all(1);
    // R4: each pair-banked mode
    set_mode(5'b10011); read_all(2);
    write_reg(13, 32'h3000_000D); write_reg(14, 32'h3000_000E); write_reg(2, 32'h3333_0002);
    set_mode(5'b10111); write_reg(13, 32'h4000_000D); read_all(7);
    set_mode(5'b10000); read_all(4);
    // R8: exception entry into normal interrupt
    exc_take = 1; exc_mode = 5'b10010; exc_ret = 32'hAAAA_0004; cpsr_in = 32'h6000_0010;
    ra_idx = 4'd14; tick();
    read_all(0);
    // R9: exception beats software mode write; regular write uses old mode
    exc_take = 1; exc_mode = 5'b11011; exc_ret = 32'hBBBB_0008; cpsr_in = 32'h8000_0012;
    mode_we = 1; mode_wdata = 5'b10111;
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'h5555_000E; tick();
    read_all(6);
    set_mode(5'b10010); ra_idx = 4'd14; rb_idx = 4'd13; tick();
    // R9: capture wins over regular write to the same link register
    set_mode(5'b11011);
    exc_take = 1; exc_mode = 5'b11011; exc_ret = 32'hCCCC_0010; cpsr_in = 32'h2000_001B;
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'h7777_7777; tick();
    ra_idx = 4'd14; tick();
    // R6: writes to register 15 go out, not into the array
    pc_in = 32'h0000_2000;
    wr_en = 1; wr_idx = 4'd15; wr_data = 32'hDEAD_BEE0; ra_idx = 4'd15; tick();
    read_all(9);
    // R11: unknown encoding acts as user
    set_mode(5'b10101); read_all(8);
    exc_take = 1; exc_mode = 5'b10001; exc_ret = 32'hF1F1_0004; cpsr_in = 32'h4000_0015; tick();
    read_all(11);
    finish_run();
  end
endmodule